// File: doc/BRIEF.md
# LRU Page Read Cache

This block is a per-port read cache placed between a narrow 32-bit read/write request bus and a flash array that returns 128-bit lines. It keeps four line buffers, each tagged with the page index of the line it holds. Any buffer can hold any page. A read that finds its page in a valid buffer is answered in the cycle after it is accepted, without touching the array. A read that misses asks the array for the whole 128-bit page. It fills a free buffer, or the least recently used one when all four are full, and then answers. When prefetch is enabled, the controller then fetches the following page into the cache, unless that page is already held.

Reads of one, two or four bytes are accepted at any offset, provided all the requested bytes lie inside one aligned 32-bit word. Writes are passed to the array's 64-bit write path only when they are full words at a word-aligned address. A write that reaches the array also drops any buffer holding the page it touches. Two configuration inputs turn buffering and prefetch on or off independently. With buffering off, every read goes to the array.

Top module: `page_read_cache`

## Requirements
- R1: After reset all four buffers are invalid, `req_ready` is 1, `rsp_valid`, `arr_rd_req` and `arr_wr_req` are 0, and the first read of any page makes one array read.
- R2: A legal read whose page is held in a valid buffer, with `cfg_buf_en`=1, is answered with `rsp_valid`=1 in the cycle right after acceptance, and makes no array read.
- R3: A read miss requests page index `req_addr[AW-1:4]` on `arr_rd_page`. The 32-bit word at `req_addr[3:2]`=k is taken from `arr_rd_line[32*k+31:32*k]`. The response follows the cycle in which `arr_rd_ack` is seen.
- R4: A miss fills an invalid buffer if one exists, otherwise the least recently used one. A buffer becomes most recently used when it is filled or hit.
- R5: `req_size` 0, 1 and 2 read 1, 2 and 4 bytes. The data is little-endian, starting at byte `req_addr[1:0]` of its word, shifted down to bit 0 and zero-extended in `rsp_rdata`.
- R6: A read with `req_size`=3, or whose bytes run past the end of the aligned 32-bit word, gets `rsp_err`=1 and `rsp_rdata`=0 in the next cycle, with no array read.
- R7: A write with `req_size`=2 and `req_addr[1:0]`=0 drives `arr_wr_dw`=`req_addr[AW-1:3]` and the word on both halves of `arr_wr_data`. It drives `arr_wr_be`=0x0F when `req_addr[2]`=0 and 0xF0 when it is 1. It is answered (`rsp_err`=0) after `arr_wr_ack`. Any other write gets `rsp_err`=1 at once and never reaches the array.
- R8: An accepted legal write invalidates the buffer holding its page, so the next read of that page fetches from the array and returns the new data.
- R9: With `cfg_buf_en`=1 and `cfg_pf_en`=1, a demand fill is followed by an array read of the next page index (modulo the page space), unless that page is already held. The prefetched page is then a hit.
- R10: While a prefetch is in flight `req_ready` is 0. A read held back then is accepted afterwards, and hits if it targets the prefetched page.
- R11: With `cfg_buf_en`=0 every legal read makes exactly one array read, with no fill and no prefetch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_buf_en | input | 1 | Enable line buffering |
| cfg_pf_en | input | 1 | Enable next-page prefetch |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle when valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | 0 byte, 1 halfword, 2 word, 3 reserved |
| req_addr | input | AW | Byte address |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response present (one cycle) |
| rsp_rdata | output | 32 | Read data, right-justified |
| rsp_err | output | 1 | Request rejected |
| arr_rd_req | output | 1 | Array line read request |
| arr_rd_page | output | AW-4 | Page index to read |
| arr_rd_ack | input | 1 | Array line read done |
| arr_rd_line | input | 128 | Array line data |
| arr_wr_req | output | 1 | Array write request |
| arr_wr_dw | output | AW-3 | Doubleword address of write |
| arr_wr_data | output | 64 | Write data, word on both halves |
| arr_wr_be | output | 8 | Byte enables of the write |
| arr_wr_ack | input | 1 | Array write done |

## Verification
A stale or misplaced tag shows at the ports as a wrong data word on the very next response to a read of that page. A wrongly kept valid bit after a write shows as old data returned without any array read. A faulty recency order shows one miss later, as an extra array read for a page that should have stayed, or as a missing one for a page that should have gone. The bench therefore counts array reads after every sequence and checks hit latency per response, so each such fault is seen within a few requests.

// File: rtl/prc_pkg.sv
package prc_pkg;
  localparam int BUS_W   = 32;
  localparam int LINE_W  = 128;
  localparam int AWR_W   = 64;
  localparam int LINE_BY = LINE_W / 8;
  localparam int OFF_W   = $clog2(LINE_BY);

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_RSVD = 2'd3
  } xfer_size_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FETCH = 2'd1,
    ST_PREF  = 2'd2,
    ST_WRITE = 2'd3
  } ctl_state_e;

  // true when the access leaves its aligned 32-bit word or uses the reserved size
  function automatic logic spans_word(input logic [1:0] lo, input logic [1:0] sz);
    logic [2:0] last;
    last = {1'b0, lo} + (3'd1 << sz);
    return (sz == 2'd3) || (last > 3'd4);
  endfunction

  function automatic logic [BUS_W-1:0] pick_bytes(input logic [LINE_W-1:0] line,
                                                   input logic [OFF_W-1:0] off,
                                                   input logic [1:0] sz);
    logic [BUS_W-1:0] word;
    logic [BUS_W-1:0] sh;
    word = line[BUS_W*off[OFF_W-1:2] +: BUS_W];
    sh   = word >> {off[1:0], 3'b000};
    case (sz)
      2'd0:    return {24'h0, sh[7:0]};
      2'd1:    return {16'h0, sh[15:0]};
      default: return sh;
    endcase
  endfunction
endpackage

// File: rtl/prc_lru.sv
module prc_lru #(
  parameter int N = 4,
  localparam int RW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          touch_en,
  input  logic [RW-1:0] touch_idx,
  output logic [RW-1:0] lru_idx
);
  logic [RW-1:0] rank [N];
  logic [N-1:0]  is_old;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < N; i++) rank[i] <= RW'(i);
    end else if (touch_en) begin
      for (int i = 0; i < N; i++) begin
        if (RW'(i) == touch_idx)             rank[i] <= '0;
        else if (rank[i] < rank[touch_idx])  rank[i] <= rank[i] + RW'(1);
      end
    end
  end

  always_comb begin
    lru_idx = '0;
    for (int i = 0; i < N; i++) begin
      is_old[i] = (rank[i] == RW'(N - 1));
      if (is_old[i]) lru_idx = RW'(i);
    end
  end

  // R4
  lru_single_chk: assert property (@(posedge clk) disable iff (rst)
    $countones(is_old) == 1);

  generate
    if (N > 1) begin : g_touch_chk
      // R4
      lru_touch_chk: assert property (@(posedge clk) disable iff (rst)
        touch_en |=> lru_idx != $past(touch_idx));
    end
  endgenerate
endmodule

// File: rtl/prc_tagset.sv
module prc_tagset #(
  parameter int N    = 4,
  parameter int PG_W = 12,
  localparam int IW  = (N > 1) ? $clog2(N) : 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [PG_W-1:0] q0_page,
  output logic            q0_hit,
  output logic [IW-1:0]   q0_idx,
  input  logic [PG_W-1:0] q1_page,
  output logic            q1_hit,
  output logic [IW-1:0]   q1_idx,
  input  logic            fill_en,
  input  logic [IW-1:0]   fill_idx,
  input  logic [PG_W-1:0] fill_page,
  input  logic            inv_en,
  input  logic [IW-1:0]   inv_idx,
  output logic [N-1:0]    valid_o
);
  logic [PG_W-1:0] tag [N];
  logic [N-1:0]    vld;
  logic [N-1:0]    m0, m1;

  always_ff @(posedge clk) begin
    if (rst) begin
      vld <= '0;
      for (int i = 0; i < N; i++) tag[i] <= '0;
    end else begin
      if (fill_en) begin
        vld[fill_idx] <= 1'b1;
        tag[fill_idx] <= fill_page;
      end
      if (inv_en) vld[inv_idx] <= 1'b0;
    end
  end

  genvar g;
  generate
    for (g = 0; g < N; g++) begin : g_cmp
      assign m0[g] = vld[g] && (tag[g] == q0_page);
      assign m1[g] = vld[g] && (tag[g] == q1_page);
    end
  endgenerate

  always_comb begin
    q0_idx = '0;
    q1_idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (m0[i]) q0_idx = IW'(i);
      if (m1[i]) q1_idx = IW'(i);
    end
  end

  assign q0_hit  = |m0;
  assign q1_hit  = |m1;
  assign valid_o = vld;

  logic dup;
  always_comb begin
    dup = 1'b0;
    for (int i = 0; i < N; i++)
      for (int j = i + 1; j < N; j++)
        if (vld[i] && vld[j] && (tag[i] == tag[j])) dup = 1'b1;
  end

  // R9
  no_dup_tag_chk: assert property (@(posedge clk) disable iff (rst) !dup);
endmodule

// File: rtl/prc_linemem.sv
module prc_linemem #(
  parameter int N  = 4,
  parameter int W  = 128,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          we,
  input  logic [IW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [IW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [N];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/page_read_cache.sv
module page_read_cache
  import prc_pkg::*;
#(
  parameter int AW   = 16,
  parameter int NENT = 4,
  localparam int PG_W = AW - OFF_W,
  localparam int DW_W = AW - 3,
  localparam int IW   = (NENT > 1) ? $clog2(NENT) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_buf_en,
  input  logic              cfg_pf_en,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [1:0]        req_size,
  input  logic [AW-1:0]     req_addr,
  input  logic [BUS_W-1:0]  req_wdata,
  output logic              rsp_valid,
  output logic [BUS_W-1:0]  rsp_rdata,
  output logic              rsp_err,
  output logic              arr_rd_req,
  output logic [PG_W-1:0]   arr_rd_page,
  input  logic              arr_rd_ack,
  input  logic [LINE_W-1:0] arr_rd_line,
  output logic              arr_wr_req,
  output logic [DW_W-1:0]   arr_wr_dw,
  output logic [AWR_W-1:0]  arr_wr_data,
  output logic [7:0]        arr_wr_be,
  input  logic              arr_wr_ack
);
  ctl_state_e        state;
  logic [AW-1:0]     cur_addr;
  logic [1:0]        cur_size;
  logic [PG_W-1:0]   pf_page;
  logic [BUS_W-1:0]  wlatch;

  logic              acc, rd_bad, wr_ok;
  logic [PG_W-1:0]   cur_page, nxt_page;
  logic              q0_hit, q1_hit;
  logic [IW-1:0]     q0_idx, q1_idx, lru_idx, vic;
  logic [NENT-1:0]   valid;
  logic              fill_en, touch_en, inv_en, pf_go, hit_rd;
  logic [IW-1:0]     touch_idx;
  logic [PG_W-1:0]   fill_page;
  logic [LINE_W-1:0] ram_q;

  assign req_ready = (state == ST_IDLE);
  assign acc       = req_valid && req_ready;
  assign rd_bad    = spans_word(req_addr[1:0], req_size);
  assign wr_ok     = (req_size == SZ_WORD) && (req_addr[1:0] == 2'b00);
  assign cur_page  = cur_addr[AW-1:OFF_W];
  assign nxt_page  = cur_page + PG_W'(1);
  assign hit_rd    = acc && !req_write && !rd_bad && cfg_buf_en && q0_hit;

  // victim: lowest invalid buffer, else the least recently used
  always_comb begin
    vic = lru_idx;
    for (int i = NENT - 1; i >= 0; i--)
      if (!valid[i]) vic = IW'(i);
  end

  assign fill_en   = arr_rd_ack && cfg_buf_en && (state == ST_FETCH || state == ST_PREF);
  assign fill_page = (state == ST_PREF) ? pf_page : cur_page;
  assign touch_en  = fill_en || hit_rd;
  assign touch_idx = fill_en ? vic : q0_idx;
  assign inv_en    = acc && req_write && wr_ok && q0_hit;
  assign pf_go     = cfg_buf_en && cfg_pf_en && !(q1_hit && (q1_idx != vic));

  prc_tagset #(.N(NENT), .PG_W(PG_W)) u_tags (
    .clk       (clk),
    .rst       (rst),
    .q0_page   (req_addr[AW-1:OFF_W]),
    .q0_hit    (q0_hit),
    .q0_idx    (q0_idx),
    .q1_page   (nxt_page),
    .q1_hit    (q1_hit),
    .q1_idx    (q1_idx),
    .fill_en   (fill_en),
    .fill_idx  (vic),
    .fill_page (fill_page),
    .inv_en    (inv_en),
    .inv_idx   (q0_idx),
    .valid_o   (valid)
  );

  prc_lru #(.N(NENT)) u_lru (
    .clk       (clk),
    .rst       (rst),
    .touch_en  (touch_en),
    .touch_idx (touch_idx),
    .lru_idx   (lru_idx)
  );

  prc_linemem #(.N(NENT), .W(LINE_W)) u_mem (
    .clk   (clk),
    .we    (fill_en),
    .waddr (vic),
    .wdata (arr_rd_line),
    .raddr (q0_idx),
    .rdata (ram_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      cur_addr  <= '0;
      cur_size  <= '0;
      pf_page   <= '0;
      wlatch    <= '0;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
      rsp_err   <= 1'b0;
    end else begin
      rsp_valid <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (req_valid) begin
            cur_addr <= req_addr;
            cur_size <= req_size;
            wlatch   <= req_wdata;
            if (req_write) begin
              if (wr_ok) begin
                state <= ST_WRITE;
              end else begin
                rsp_valid <= 1'b1;
                rsp_err   <= 1'b1;
                rsp_rdata <= '0;
              end
            end else if (rd_bad) begin
              rsp_valid <= 1'b1;
              rsp_err   <= 1'b1;
              rsp_rdata <= '0;
            end else if (cfg_buf_en && q0_hit) begin
              rsp_valid <= 1'b1;
              rsp_err   <= 1'b0;
              rsp_rdata <= pick_bytes(ram_q, req_addr[OFF_W-1:0], req_size);
            end else begin
              state <= ST_FETCH;
            end
          end
        end
        ST_FETCH: begin
          if (arr_rd_ack) begin
            rsp_valid <= 1'b1;
            rsp_err   <= 1'b0;
            rsp_rdata <= pick_bytes(arr_rd_line, cur_addr[OFF_W-1:0], cur_size);
            if (pf_go) begin
              pf_page <= nxt_page;
              state   <= ST_PREF;
            end else begin
              state   <= ST_IDLE;
            end
          end
        end
        ST_PREF: begin
          if (arr_rd_ack) state <= ST_IDLE;
        end
        ST_WRITE: begin
          if (arr_wr_ack) begin
            rsp_valid <= 1'b1;
            rsp_err   <= 1'b0;
            rsp_rdata <= '0;
            state     <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign arr_rd_req  = (state == ST_FETCH) || (state == ST_PREF);
  assign arr_rd_page = (state == ST_PREF) ? pf_page : cur_page;
  assign arr_wr_req  = (state == ST_WRITE);
  assign arr_wr_dw   = cur_addr[AW-1:3];
  assign arr_wr_data = {wlatch, wlatch};
  assign arr_wr_be   = cur_addr[2] ? 8'hF0 : 8'h0F;

  // R2
  hit_zero_wait_chk: assert property (@(posedge clk) disable iff (rst)
    hit_rd |=> rsp_valid && !rsp_err && !arr_rd_req);

  // R6
  bad_read_chk: assert property (@(posedge clk) disable iff (rst)
    (acc && !req_write && rd_bad) |=> rsp_valid && rsp_err && !arr_rd_req);

  // R7
  bad_write_chk: assert property (@(posedge clk) disable iff (rst)
    (acc && req_write && !wr_ok) |=> rsp_valid && rsp_err && !arr_wr_req);

  // R7
  rw_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(arr_rd_req && arr_wr_req));

  // R8
  write_inval_chk: assert property (@(posedge clk) disable iff (rst)
    inv_en |=> !valid[$past(q0_idx)]);

  // R9
  pf_next_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_FETCH && arr_rd_ack && cfg_buf_en && cfg_pf_en && !q1_hit)
      |=> arr_rd_req && (arr_rd_page == $past(nxt_page)));

  // R11
  nobuf_array_chk: assert property (@(posedge clk) disable iff (rst)
    (acc && !req_write && !rd_bad && !cfg_buf_en) |=> arr_rd_req);
endmodule

// File: tb/tb_page_read_cache.sv
`timescale 1ns/1ps
module tb_page_read_cache;
  localparam int AW   = 16;
  localparam int PG_W = AW - 4;
  localparam int RLAT = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic              cfg_buf_en, cfg_pf_en;
  logic              req_valid, req_ready, req_write;
  logic [1:0]        req_size;
  logic [AW-1:0]     req_addr;
  logic [31:0]       req_wdata;
  logic              rsp_valid, rsp_err;
  logic [31:0]       rsp_rdata;
  logic              arr_rd_req, arr_rd_ack;
  logic [PG_W-1:0]   arr_rd_page;
  logic [127:0]      arr_rd_line;
  logic              arr_wr_req, arr_wr_ack;
  logic [AW-4:0]     arr_wr_dw;
  logic [63:0]       arr_wr_data;
  logic [7:0]        arr_wr_be;

  page_read_cache #(.AW(AW), .NENT(4)) dut (
    .clk(clk), .rst(rst), .cfg_buf_en(cfg_buf_en), .cfg_pf_en(cfg_pf_en),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_size(req_size), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
    .arr_rd_req(arr_rd_req), .arr_rd_page(arr_rd_page), .arr_rd_ack(arr_rd_ack),
    .arr_rd_line(arr_rd_line), .arr_wr_req(arr_wr_req), .arr_wr_dw(arr_wr_dw),
    .arr_wr_data(arr_wr_data), .arr_wr_be(arr_wr_be), .arr_wr_ack(arr_wr_ack)
  );

  int total = 0;
  int bad   = 0;
  int cyc   = 0;
  bit done  = 0;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string rq, input string what,
                     input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s act=%0h exp=%0h", rq, what, act, exp);
    end
  endtask

  // ---------------- array model ----------------
  logic [31:0] wmem [int];
  int nrd = 0, nwr = 0, rcnt = 0, wcnt = 0;
  logic [PG_W-1:0] last_rd;
  logic [AW-4:0]   last_wdw;
  logic [7:0]      last_be;
  logic [63:0]     last_wd;

  function automatic logic [31:0] mword(input int wa);
    if (wmem.exists(wa)) return wmem[wa];
    return (32'(wa) * 32'h9E3779B1) ^ 32'h13579BDF;
  endfunction

  initial begin
    arr_rd_ack = 0; arr_rd_line = '0;
    forever begin
      @(negedge clk);
      if (rst) begin
        arr_rd_ack = 0; rcnt = 0;
      end else if (arr_rd_ack) begin
        arr_rd_ack = 0;
      end else if (arr_rd_req) begin
        if (rcnt >= RLAT) begin
          for (int k = 0; k < 4; k++)
            arr_rd_line[32*k +: 32] = mword(int'(arr_rd_page) * 4 + k);
          arr_rd_ack = 1; rcnt = 0; nrd++; last_rd = arr_rd_page;
        end else rcnt++;
      end
    end
  end

  initial begin
    arr_wr_ack = 0;
    forever begin
      @(negedge clk);
      if (rst) begin
        arr_wr_ack = 0; wcnt = 0;
      end else if (arr_wr_ack) begin
        arr_wr_ack = 0;
      end else if (arr_wr_req) begin
        if (wcnt >= 2) begin
          last_wdw = arr_wr_dw; last_be = arr_wr_be; last_wd = arr_wr_data;
          if (arr_wr_be == 8'h0F) wmem[int'(arr_wr_dw) * 2]     = arr_wr_data[31:0];
          if (arr_wr_be == 8'hF0) wmem[int'(arr_wr_dw) * 2 + 1] = arr_wr_data[63:32];
          arr_wr_ack = 1; wcnt = 0; nwr++;
        end else wcnt++;
      end
    end
  end

  // ---------------- scoreboard ----------------
  typedef struct {
    logic [31:0] d;
    bit          e;
    int          acc;
    bit          hit;
    string       tag;
  } exp_t;
  exp_t sbq[$];

  always @(negedge clk) begin
    if (!rst && rsp_valid) begin
      if (sbq.size() == 0) begin
        chk(0, "R1", "unexpected response", rsp_rdata, 0);
      end else begin
        exp_t it;
        it = sbq.pop_front();
        chk(rsp_err == it.e, it.tag, "rsp_err", rsp_err, it.e);
        chk(rsp_rdata == it.d, it.tag, "rsp_rdata", rsp_rdata, it.d);
        if (it.hit) chk(cyc == it.acc, it.tag, "hit latency cycle", cyc, it.acc);
      end
    end
  end

  function automatic logic [31:0] exp_read(input logic [AW-1:0] a, input logic [1:0] sz);
    logic [31:0] w;
    w = mword(int'(a >> 2)) >> (8 * a[1:0]);
    case (sz)
      2'd0:    return {24'h0, w[7:0]};
      2'd1:    return {16'h0, w[15:0]};
      default: return w;
    endcase
  endfunction

  task automatic issue(input bit w, input logic [AW-1:0] a, input logic [1:0] sz,
                       input logic [31:0] wd, input bit hit, input string tag,
                       output int waited);
    exp_t it;
    bit illegal;
    @(negedge clk);
    req_valid = 1; req_write = w; req_addr = a; req_size = sz; req_wdata = wd;
    waited = 0;
    while (!req_ready) begin
      @(negedge clk);
      waited++;
    end
    if (w) illegal = (sz != 2'd2) || (a[1:0] != 2'd0);
    else   illegal = (sz == 2'd3) || (int'(a[1:0]) + (1 << sz) > 4);
    it.e   = illegal;
    it.d   = (illegal || w) ? 32'h0 : exp_read(a, sz);
    it.acc = cyc + 1;
    it.hit = hit;
    it.tag = tag;
    sbq.push_back(it);
    @(posedge clk);
    #1 req_valid = 0;
  endtask

  task automatic rd(input logic [AW-1:0] a, input logic [1:0] sz, input bit hit, input string tag);
    int wt;
    issue(0, a, sz, 32'h0, hit, tag, wt);
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [1:0] sz, input logic [31:0] d, input string tag);
    int wt;
    issue(1, a, sz, d, 0, tag, wt);
  endtask

  task automatic settle();
    @(negedge clk);
    while (!req_ready || sbq.size() != 0) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL R1 watchdog act=hung exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int n0, w0, wt;
    cfg_buf_en = 1; cfg_pf_en = 0;
    req_valid = 0; req_write = 0; req_size = 0; req_addr = '0; req_wdata = '0;
    repeat (5) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    chk(req_ready == 1, "R1", "req_ready after reset", req_ready, 1);
    chk(rsp_valid == 0, "R1", "rsp_valid after reset", rsp_valid, 0);
    chk(arr_rd_req == 0 && arr_wr_req == 0, "R1", "array idle after reset",
        {arr_rd_req, arr_wr_req}, 0);

    // R1 / R3 first read misses
    n0 = nrd;
    rd(16'h0010, 2'd2, 0, "R3"); settle();
    chk(nrd == n0 + 1, "R1", "array reads on first access", nrd - n0, 1);
    chk(last_rd == 12'h001, "R3", "page index requested", last_rd, 1);

    // R2 / R5 hits of all sizes and offsets
    n0 = nrd;
    rd(16'h0010, 2'd2, 1, "R2");
    rd(16'h0011, 2'd0, 1, "R5");
    rd(16'h0013, 2'd0, 1, "R5");
    rd(16'h0012, 2'd1, 1, "R5");
    rd(16'h0011, 2'd1, 1, "R5");
    rd(16'h0014, 2'd2, 1, "R3");
    rd(16'h001F, 2'd0, 1, "R5");
    rd(16'h001C, 2'd2, 1, "R3");
    settle();
    chk(nrd == n0, "R2", "no array read on hits", nrd - n0, 0);

    // R6 illegal reads
    n0 = nrd;
    rd(16'h0013, 2'd1, 1, "R6");
    rd(16'h0011, 2'd2, 1, "R6");
    rd(16'h0012, 2'd2, 1, "R6");
    rd(16'h0010, 2'd3, 1, "R6");
    rd(16'h0093, 2'd1, 1, "R6");
    settle();
    chk(nrd == n0, "R6", "no array read on rejected reads", nrd - n0, 0);

    // R4 replacement order
    n0 = nrd;
    rd(16'h0020, 2'd2, 0, "R4");
    rd(16'h0030, 2'd2, 0, "R4");
    rd(16'h0040, 2'd2, 0, "R4");
    settle();
    chk(nrd == n0 + 3, "R4", "fills of free buffers", nrd - n0, 3);
    rd(16'h0018, 2'd2, 1, "R4");
    n0 = nrd;
    rd(16'h0050, 2'd2, 0, "R4"); settle();
    chk(nrd == n0 + 1, "R4", "miss replaces one buffer", nrd - n0, 1);
    n0 = nrd;
    rd(16'h0010, 2'd2, 1, "R4");
    rd(16'h0030, 2'd2, 1, "R4");
    rd(16'h0040, 2'd2, 1, "R4");
    rd(16'h0050, 2'd2, 1, "R4");
    settle();
    chk(nrd == n0, "R4", "recently used pages kept", nrd - n0, 0);
    n0 = nrd;
    rd(16'h0020, 2'd2, 0, "R4"); settle();
    chk(nrd == n0 + 1, "R4", "evicted page misses", nrd - n0, 1);
    n0 = nrd;
    rd(16'h0010, 2'd2, 0, "R4"); settle();
    chk(nrd == n0 + 1, "R4", "oldest page chosen as victim", nrd - n0, 1);
    n0 = nrd;
    rd(16'h0040, 2'd2, 1, "R4"); settle();
    chk(nrd == n0, "R4", "page 4 still held", nrd - n0, 0);

    // R7 legal writes
    w0 = nwr;
    wr(16'h0044, 2'd2, 32'hCAFEF00D, "R7"); settle();
    chk(nwr == w0 + 1, "R7", "array write count", nwr - w0, 1);
    chk(last_wdw == 13'h0008, "R7", "doubleword address", last_wdw, 8);
    chk(last_be == 8'hF0, "R7", "upper byte enables", last_be, 8'hF0);
    chk(last_wd[63:32] == 32'hCAFEF00D, "R7", "upper write data", last_wd[63:32], 32'hCAFEF00D);
    wr(16'h0040, 2'd2, 32'h12345678, "R7"); settle();
    chk(last_be == 8'h0F, "R7", "lower byte enables", last_be, 8'h0F);
    chk(last_wd[31:0] == 32'h12345678, "R7", "lower write data", last_wd[31:0], 32'h12345678);

    // R8 invalidation on write
    n0 = nrd;
    rd(16'h0044, 2'd2, 0, "R8"); settle();
    chk(nrd == n0 + 1, "R8", "written page refetched", nrd - n0, 1);
    rd(16'h0040, 2'd2, 1, "R8"); settle();

    // R7 illegal writes never reach the array
    w0 = nwr;
    wr(16'h0052, 2'd2, 32'hDEADBEEF, "R7");
    wr(16'h0050, 2'd1, 32'hDEADBEEF, "R7");
    settle();
    chk(nwr == w0, "R7", "rejected writes not sent", nwr - w0, 0);
    rd(16'h0050, 2'd2, 0, "R7"); settle();

    // R11 buffering off
    cfg_buf_en = 0; cfg_pf_en = 1;
    n0 = nrd;
    rd(16'h0040, 2'd2, 0, "R11");
    rd(16'h0040, 2'd2, 0, "R11");
    settle();
    chk(nrd == n0 + 2, "R11", "every read to array, no prefetch", nrd - n0, 2);

    // R9 prefetch
    cfg_buf_en = 1; cfg_pf_en = 1;
    n0 = nrd;
    rd(16'h0800, 2'd2, 0, "R9"); settle();
    chk(nrd == n0 + 2, "R9", "demand plus prefetch", nrd - n0, 2);
    chk(last_rd == 12'h081, "R9", "prefetched page index", last_rd, 12'h081);
    n0 = nrd;
    rd(16'h0818, 2'd2, 1, "R9"); settle();
    chk(nrd == n0, "R9", "prefetched page hits", nrd - n0, 0);
    n0 = nrd;
    rd(16'h0A10, 2'd2, 0, "R9"); settle();
    rd(16'h0A00, 2'd2, 0, "R9"); settle();
    chk(nrd == n0 + 3, "R9", "prefetch skipped when next page held", nrd - n0, 3);

    // R10 read held back during prefetch
    n0 = nrd;
    rd(16'h0C00, 2'd2, 0, "R10");
    issue(0, 16'h0C14, 2'd2, 32'h0, 1, "R10", wt);
    settle();
    chk(wt > 0, "R10", "request stalled during fetch/prefetch", wt, 1);
    chk(nrd == n0 + 2, "R10", "stalled read served from prefetch", nrd - n0, 2);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule